// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block turns a fast peripheral clock into the phase timing of an I2C master's serial clock. Each SCL period is split into a low half and a high half, and each half has its own 16-bit count. A half is cut into eight sub-steps, and each sub-step lasts one more clock than the count for that half. So the low half takes 8 × (low + 1) clocks, the high half takes 8 × (high + 1) clocks, and the period is 8 × ((low + 1) + (high + 1)) clocks. With both counts at zero the period is 16 clocks, the shortest there is.

The bit engine that sits next to this block reads its outputs: a level for SCL, an enable for each half, the current sub-step index, and one-cycle strobes. The strobes mark the falling edge, the middle of the low half (where SDA may change), the rising edge, the middle of the high half (where SDA is sampled) and the last clock of each bit. A sequencer asks for clocking with a run request. A new divider word only takes effect when the next low half begins, so a bit is never stretched or shortened part way through. When the enable drops, everything returns to idle and SCL is released.

Top module: `scl_timing_gen`

## Requirements
- R1: The divider word carries the high-half count in bits 31:16 and the low-half count in bits 15:0.
- R2: The low half lasts exactly 8 × (low + 1) clocks. Through all of it low_en is 1 and scl_o is 0.
- R3: The high half lasts exactly 8 × (high + 1) clocks. Through all of it high_en is 1 and scl_o is 1 (1 means released). The period is the sum of the two halves.
- R4: With both counts at zero, the low half lasts 8 clocks and the whole period lasts 16 clocks.
- R5: sub_step counts 0 to 7 within each half. In the low half it moves on every (low + 1) clocks, and in the high half every (high + 1) clocks. It reads 4 on the clock of each midpoint strobe.
- R6: fall_stb pulses on the first clock of the low half, which is index 0. drive_stb pulses exactly once per low half, at index 4 × (low + 1).
- R7: rise_stb pulses on the first clock of the high half. sample_stb pulses once, 4 × (high + 1) clocks after rise_stb. bit_end pulses on the last clock of the high half.
- R8: A change to the divider word while a period is running does not affect that period. The new counts apply from the start of the next low half.
- R9: While the block is idle and enabled, raising run starts the low half on the next clock. If run drops during a period, that period finishes in full. The block then stays idle, with scl_o = 1 and both enables at 0.
- R10: One clock after en goes to 0, the block is idle, with scl_o = 1, both enables at 0, sub_step 0 and no strobes. It stays idle while en is 0. When en returns with run high, a new low half starts on the next clock.
- R11: During reset and just after it, the outputs show the idle state: scl_o = 1, both enables at 0 and no strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; 0 holds the counters cleared and SCL released |
| run | input | 1 | Clocking request from the sequencer |
| div_word | input | 32 | Packed divider: high count [31:16], low count [15:0] |
| scl_o | output | 1 | SCL level; 1 = released, 0 = driven low |
| low_en | output | 1 | High during the SCL low half |
| high_en | output | 1 | High during the SCL high half |
| sub_step | output | 3 | Sub-step index within the current half |
| fall_stb | output | 1 | First clock of the low half |
| drive_stb | output | 1 | Midpoint of the low half; SDA may change |
| rise_stb | output | 1 | First clock of the high half |
| sample_stb | output | 1 | Midpoint of the high half; SDA is sampled |
| bit_end | output | 1 | Last clock of the high half |

## Verification
Any error in the prescaler or the sub-step counter shows up within one period. A half comes out with the wrong length, or a midpoint strobe lands away from its computed index, or sub_step reads the wrong value in the middle of a sub-step. A divider word latched at the wrong moment shows up as a period that uses the new counts too early, which the bench sees by changing the word in the middle of a bit. A phase register that does not clear, or does not stop, shows up one clock later as scl_o held low, or as a fall_stb after a stop or a disable.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Length of one half in clocks: steps sub-steps of (cnt + 1) clocks each.
  function automatic logic [31:0] phase_len(input logic [31:0] cnt, input int unsigned steps);
    return 32'(steps) * (cnt + 32'd1);
  endfunction

  // Sub-step index at which a midpoint strobe fires.
  function automatic int unsigned mid_step(input int unsigned steps);
    return steps / 2;
  endfunction

endpackage

// File: rtl/scl_div_latch.sv
module scl_div_latch #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV_W = 2 * CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [DIV_W-1:0] div_word,
  output logic [CNT_W-1:0] lo_cnt,
  output logic [CNT_W-1:0] hi_cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else if (clr) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else if (load) begin
      lo_cnt <= div_word[CNT_W-1:0];
      hi_cnt <= div_word[DIV_W-1:CNT_W];
    end
  end

  // R8: the latched counts change only when a low half starts
  a_r8_counts_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr) |=> $stable({hi_cnt, lo_cnt}));

endmodule

// File: rtl/scl_step_counter.sv
module scl_step_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned STEPS = 8,
  parameter int unsigned SUB_W = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             active,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] pre_cnt,
  output logic [SUB_W-1:0] sub_cnt,
  output logic             step_last,
  output logic             phase_last
);

  localparam logic [SUB_W-1:0] SUB_MAX = SUB_W'(STEPS - 1);

  assign step_last  = active && (pre_cnt == limit);
  assign phase_last = step_last && (sub_cnt == SUB_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      sub_cnt <= '0;
    end else if (clr || !active) begin
      pre_cnt <= '0;
      sub_cnt <= '0;
    end else if (step_last) begin
      pre_cnt <= '0;
      sub_cnt <= phase_last ? '0 : sub_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // R5: the prescaler never runs past the limit of the current half
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (pre_cnt <= limit));

  // R5: the sub-step index moves only on the last clock of a sub-step
  a_r5_sub_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !step_last && !clr) |=> $stable(sub_cnt));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_timing_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   run,
  input  logic   phase_last,
  output phase_e phase,
  output logic   load
);

  phase_e phase_nx;

  // A low half begins from idle or straight after a high half.
  assign load = en && run && ((phase == PH_IDLE) || ((phase == PH_HIGH) && phase_last));

  always_comb begin
    phase_nx = phase;
    if (!en) begin
      phase_nx = PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE: if (run) phase_nx = PH_LOW;
        PH_LOW:  if (phase_last) phase_nx = PH_HIGH;
        PH_HIGH: if (phase_last) phase_nx = run ? PH_LOW : PH_IDLE;
        default: phase_nx = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

  // R2: a low half is not cut short while enabled
  a_r2_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (phase == PH_LOW) && !phase_last) |=> (phase == PH_LOW));

  // R3: a high half is not cut short while enabled
  a_r3_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (phase == PH_HIGH) && !phase_last) |=> (phase == PH_HIGH));

endmodule

// File: rtl/scl_strobe_gen.sv
module scl_strobe_gen
  import scl_timing_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned STEPS = 8,
  parameter int unsigned SUB_W = $clog2(STEPS)
) (
  input  phase_e           phase,
  input  logic [CNT_W-1:0] pre_cnt,
  input  logic [SUB_W-1:0] sub_cnt,
  input  logic             phase_last,
  output logic             scl_o,
  output logic             low_en,
  output logic             high_en,
  output logic             fall_stb,
  output logic             drive_stb,
  output logic             rise_stb,
  output logic             sample_stb,
  output logic             bit_end
);

  localparam logic [SUB_W-1:0] SUB_MID = SUB_W'(mid_step(STEPS));

  logic step_first;
  logic at_first_step;
  logic at_mid_step;

  assign step_first    = (pre_cnt == '0);
  assign at_first_step = step_first && (sub_cnt == '0);
  assign at_mid_step   = step_first && (sub_cnt == SUB_MID);

  assign low_en     = (phase == PH_LOW);
  assign high_en    = (phase == PH_HIGH);
  assign scl_o      = !low_en;
  assign fall_stb   = low_en  && at_first_step;
  assign drive_stb  = low_en  && at_mid_step;
  assign rise_stb   = high_en && at_first_step;
  assign sample_stb = high_en && at_mid_step;
  assign bit_end    = high_en && phase_last;

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned STEPS = 8,
  parameter int unsigned DIV_W = 2 * CNT_W,
  parameter int unsigned SUB_W = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run,
  input  logic [DIV_W-1:0] div_word,
  output logic             scl_o,
  output logic             low_en,
  output logic             high_en,
  output logic [SUB_W-1:0] sub_step,
  output logic             fall_stb,
  output logic             drive_stb,
  output logic             rise_stb,
  output logic             sample_stb,
  output logic             bit_end
);

  phase_e           phase_w;
  logic             load_w;
  logic             active_w;
  logic             clr_w;
  logic [CNT_W-1:0] lo_cnt_w;
  logic [CNT_W-1:0] hi_cnt_w;
  logic [CNT_W-1:0] limit_w;
  logic [CNT_W-1:0] pre_cnt_w;
  logic [SUB_W-1:0] sub_cnt_w;
  logic             step_last_w;
  logic             phase_last_w;

  assign clr_w    = !en;
  assign active_w = en && (phase_w != PH_IDLE);
  assign limit_w  = (phase_w == PH_HIGH) ? hi_cnt_w : lo_cnt_w;
  assign sub_step = sub_cnt_w;

  scl_div_latch #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_w),
    .load     (load_w),
    .div_word (div_word),
    .lo_cnt   (lo_cnt_w),
    .hi_cnt   (hi_cnt_w)
  );

  scl_step_counter #(.CNT_W(CNT_W), .STEPS(STEPS), .SUB_W(SUB_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr_w),
    .active     (active_w),
    .limit      (limit_w),
    .pre_cnt    (pre_cnt_w),
    .sub_cnt    (sub_cnt_w),
    .step_last  (step_last_w),
    .phase_last (phase_last_w)
  );

  scl_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .run        (run),
    .phase_last (phase_last_w),
    .phase      (phase_w),
    .load       (load_w)
  );

  scl_strobe_gen #(.CNT_W(CNT_W), .STEPS(STEPS), .SUB_W(SUB_W)) u_strobe (
    .phase      (phase_w),
    .pre_cnt    (pre_cnt_w),
    .sub_cnt    (sub_cnt_w),
    .phase_last (phase_last_w),
    .scl_o      (scl_o),
    .low_en     (low_en),
    .high_en    (high_en),
    .fall_stb   (fall_stb),
    .drive_stb  (drive_stb),
    .rise_stb   (rise_stb),
    .sample_stb (sample_stb),
    .bit_end    (bit_end)
  );

  // Clocks spent in the current half, kept only for the length check below.
  logic [31:0] half_cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     half_cyc <= '0;
    else if (!active_w || phase_last_w) half_cyc <= '0;
    else                            half_cyc <= half_cyc + 32'd1;
  end

  // R3: every half ends after steps * (count + 1) clocks
  a_r3_half_length: assert property (@(posedge clk) disable iff (!rst_n)
    phase_last_w |-> (half_cyc == phase_len(32'(limit_w), STEPS) - 32'd1));

  // R10: one clock after disable the block is idle with SCL released
  a_r10_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl_o && !low_en && !high_en && (sub_step == '0)));

  // R7: the end of a bit is followed at once by a falling edge while running
  a_r7_end_then_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && run && en) |=> fall_stb);

  // R9: with run dropped, the end of a bit leads to idle
  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && !run && en) |=> (!low_en && !high_en && scl_o));

endmodule

// File: tb/tb_scl_timing_gen.sv
`timescale 1ns/1ps
module tb_scl_timing_gen;

  localparam int STEPS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        run = 1'b0;
  logic [31:0] div_word = '0;
  logic        scl_o, low_en, high_en;
  logic [2:0]  sub_step;
  logic        fall_stb, drive_stb, rise_stb, sample_stb, bit_end;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  scl_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .run(run), .div_word(div_word),
    .scl_o(scl_o), .low_en(low_en), .high_en(high_en), .sub_step(sub_step),
    .fall_stb(fall_stb), .drive_stb(drive_stb), .rise_stb(rise_stb),
    .sample_stb(sample_stb), .bit_end(bit_end)
  );

  function automatic int exp_low(input int l);  return STEPS * (l + 1); endfunction
  function automatic int exp_high(input int h); return STEPS * (h + 1); endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input int l, input int h);
    return {16'(h), 16'(l)};
  endfunction

  int m_lo, m_hi, m_drv, m_smp, m_rise, m_be, m_nd, m_ns, m_dsub, m_ssub, m_sclbad, m_subbad;

  task automatic wait_fall();
    while (fall_stb !== 1'b1) @(negedge clk);
  endtask

  // Observes one period starting at the current fall_stb sample.
  task automatic measure(input int l, input int h, input bit chg, input logic [31:0] nd, input bit stp);
    int t;
    t = 0;
    m_lo = 0; m_hi = 0; m_drv = -1; m_smp = -1; m_rise = -1; m_be = -1;
    m_nd = 0; m_ns = 0; m_dsub = -1; m_ssub = -1; m_sclbad = 0; m_subbad = 0;
    forever begin
      if (!low_en && !high_en) break;
      if (low_en && m_hi > 0) break;
      if (drive_stb)  begin m_nd++; m_drv = t; m_dsub = int'(sub_step); end
      if (sample_stb) begin m_ns++; m_smp = t; m_ssub = int'(sub_step); end
      if (rise_stb) m_rise = t;
      if (bit_end)  m_be = t;
      if (low_en) begin
        if (scl_o !== 1'b0) m_sclbad++;
        if (int'(sub_step) != t / (l + 1)) m_subbad++;
        m_lo++;
      end else begin
        if (scl_o !== 1'b1) m_sclbad++;
        if (int'(sub_step) != (t - m_lo) / (h + 1)) m_subbad++;
        m_hi++;
      end
      if (t == 2 && chg) div_word = nd;
      if (t == 2 && stp) run = 1'b0;
      @(negedge clk);
      t++;
    end
  endtask

  task automatic check_period(input int l, input int h);
    int lo_e, hi_e;
    lo_e = exp_low(l);
    hi_e = exp_high(h);
    chk(m_lo == lo_e, "R1 R2 low half length", m_lo, lo_e);
    chk(m_hi == hi_e, "R1 R3 high half length", m_hi, hi_e);
    chk(m_lo + m_hi == lo_e + hi_e, "R3 period length", m_lo + m_hi, lo_e + hi_e);
    chk(m_sclbad == 0, "R2 R3 scl level per half", m_sclbad, 0);
    chk(m_subbad == 0, "R5 sub_step progression", m_subbad, 0);
    chk(m_nd == 1 && m_drv == 4 * (l + 1), "R6 drive strobe index", m_drv, 4 * (l + 1));
    chk(m_ns == 1 && m_smp == lo_e + 4 * (h + 1), "R7 sample strobe index", m_smp, lo_e + 4 * (h + 1));
    chk(m_dsub == 4 && m_ssub == 4, "R5 sub_step at midpoints", m_dsub * 10 + m_ssub, 44);
    chk(m_rise == lo_e, "R7 rise strobe index", m_rise, lo_e);
    chk(m_be == lo_e + hi_e - 1, "R7 bit end index", m_be, lo_e + hi_e - 1);
  endtask

  task automatic run_pair(input int l, input int h);
    div_word = pack(l, h);
    @(negedge clk);
    wait_fall();
    measure(l, h, 1'b0, '0, 1'b0);
    check_period(l, h);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired: actual hung expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int bad;
    void'($urandom(32'd4711));

    // R11: reset state
    repeat (3) @(negedge clk);
    chk(scl_o && !low_en && !high_en && !fall_stb && !drive_stb && !rise_stb && !sample_stb && !bit_end,
        "R11 outputs in reset", int'(scl_o), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_o && !low_en && !high_en, "R11 idle after reset", int'(scl_o), 1);

    // R9: enabled but not running stays idle
    en = 1'b1;
    div_word = pack(3, 5);
    repeat (5) @(negedge clk);
    chk(scl_o && !low_en && !high_en && !fall_stb, "R9 idle without run", int'(low_en), 0);

    // R9: start latency of one clock
    run = 1'b1;
    @(negedge clk);
    chk(fall_stb && low_en, "R9 low half starts next clock", int'(fall_stb), 1);
    measure(3, 5, 1'b0, '0, 1'b0);
    check_period(3, 5);

    // R4: minimum period
    run_pair(0, 0);
    chk(m_lo + m_hi == 16, "R4 minimum period", m_lo + m_hi, 16);

    // R1: asymmetric fields land in the right halves
    run_pair(0, 9);
    run_pair(9, 0);
    run_pair(1, 2);
    run_pair(300, 1);

    for (int i = 0; i < 12; i++) begin
      int l, h;
      l = int'($urandom % 41);
      h = int'($urandom % 41);
      run_pair(l, h);
    end

    // R8: change mid-period takes effect on the next low half only
    run_pair(4, 2);
    measure(4, 2, 1'b1, pack(1, 7), 1'b0);
    check_period(4, 2);
    measure(1, 7, 1'b0, '0, 1'b0);
    check_period(1, 7);

    // R9: stop request finishes the current period then idles
    measure(1, 7, 1'b0, '0, 1'b1);
    check_period(1, 7);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      if (!scl_o || low_en || high_en || fall_stb) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9 idle after stop", bad, 0);

    // R9: restart from idle
    div_word = pack(2, 3);
    run = 1'b1;
    @(negedge clk);
    chk(fall_stb && low_en, "R9 restart after stop", int'(fall_stb), 1);
    measure(2, 3, 1'b0, '0, 1'b0);
    check_period(2, 3);

    // R10: disable during the low half
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(scl_o && !low_en && !high_en && sub_step == 3'd0 && !fall_stb && !drive_stb && !rise_stb && !sample_stb && !bit_end,
        "R10 idle one clock after disable", int'(scl_o), 1);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (!scl_o || low_en || high_en || fall_stb || sub_step != 3'd0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R10 held idle while disabled", bad, 0);
    en = 1'b1;
    @(negedge clk);
    chk(fall_stb && low_en, "R10 resume after enable", int'(fall_stb), 1);
    measure(2, 3, 1'b0, '0, 1'b0);
    check_period(2, 3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule